// File: doc/BRIEF.md
# Approximate Non-Restoring Array Divider

This block divides a 2N-bit unsigned dividend by an N-bit nonzero divisor in a single combinational pass and returns an N-bit quotient and an N-bit remainder. It is built as N rows of controlled add/subtract cells. Each row shifts in the next dividend bit, then subtracts or adds the divisor depending on the sign of the row above. One quotient bit leaves each row, and a final stage adds the divisor back when the last partial remainder is negative. The result is exact whenever the upper half of the dividend is smaller than the divisor, so that the quotient fits in N bits.

Parameters can trade accuracy for a smaller array. A region of the cell grid can be swapped for a cheaper approximate subtractor cell, or removed outright. The region is selected by shape and depth. A vertical region takes the lowest columns of every row. A horizontal region takes whole rows at the bottom, where the low quotient bits are formed. A square region is where those two overlap. A triangle region starts at the bottom-right corner and covers d(d+1)/2 cells. A removed cell passes its partial-remainder bit straight down, ignores the divisor bit, and produces no borrow. An illegal combination of parameters stops elaboration. Any region must leave the top row and the most significant column untouched.

Top module: `apx_div_array`

## Requirements
- R1: With `MODE`=0 (exact), for every divisor Y≠0 and dividend X with X[2N-1:N] < Y, `quot` equals floor(X/Y) and `rem` equals X mod Y. This implies X = Y·quot + rem and rem < Y.
- R2: In exact operation, any dividend smaller than the divisor gives `quot`=0 and `rem` equal to the dividend.
- R3: In exact operation, a divisor of 1 with a dividend below 2^N gives `quot` equal to the dividend and `rem`=0.
- R4: In exact operation, the largest in-range dividend Y·2^N−1 gives `quot`=2^N−1 and `rem`=Y−1 for every divisor.
- R5: Replacement (`MODE`=1) or truncation (`MODE`=2) with `DEPTH`=0 produces the exact results of R1 for any shape and any approximate cell type.
- R6: With vertical truncation (`MODE`=2, `SHAPE`=0) of depth d, the d lowest columns of each row pass the shifted partial remainder bit through unchanged. The row's remaining upper columns compute their difference with zero borrow-in, and the final negative-remainder correction is still applied.
- R7: With a horizontal (`SHAPE`=1) or triangle (`SHAPE`=3) region of depth d, in either approximate mode, quotient bits N−1 down to d equal those of the exact quotient for every in-range operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend | input | 2N | Unsigned dividend X |
| divisor | input | N | Unsigned divisor Y, must be nonzero |
| quot | output | N | Quotient, one bit per cell row, MSB from the top row |
| rem | output | N | Remainder after the final correction stage |

## Verification
The bench builds six copies of the divider at N=4. The first is exact. Two use depth 0 in the replace and truncate modes with different shapes and cell types. The others are a depth-2 vertical truncation, a depth-2 horizontal replacement using the borrow-dropping cell, and a depth-3 triangle replacement using the multiplexed-difference cell. With N=4, every in-range operand pair can be swept exhaustively. The depth-0 copies show that the region logic switches nothing on when the depth is zero. The truncated copy is compared bit for bit with a pass-through model. The two replaced copies confine any error to the quotient bits that the region's rows produce.

// File: rtl/apx_div_pkg.sv
package apx_div_pkg;

    localparam int MODE_EXACT   = 0;
    localparam int MODE_REPLACE = 1;
    localparam int MODE_TRUNC   = 2;

    localparam int SHAPE_VERT   = 0;
    localparam int SHAPE_HORZ   = 1;
    localparam int SHAPE_SQUARE = 2;
    localparam int SHAPE_TRI    = 3;

    typedef enum logic [1:0] {
        CELL_EXACT  = 2'd0,
        CELL_APPROX = 2'd1,
        CELL_GONE   = 2'd2
    } cell_kind_e;

    // lvl counts rows from the bottom (lvl 0 forms quotient bit 0),
    // col counts cells from the least significant end of a row.
    function automatic cell_kind_e cell_kind(input int mode, input int shape,
                                             input int depth, input int lvl,
                                             input int col);
        logic hit;
        case (shape)
            SHAPE_VERT:   hit = (col < depth);
            SHAPE_HORZ:   hit = (lvl < depth);
            SHAPE_SQUARE: hit = (col < depth) && (lvl < depth);
            SHAPE_TRI:    hit = (lvl + col) < depth;
            default:      hit = 1'b0;
        endcase
        if (mode == MODE_EXACT || !hit) return CELL_EXACT;
        if (mode == MODE_REPLACE) return CELL_APPROX;
        return CELL_GONE;
    endfunction

endpackage

// File: rtl/apx_div_cell.sv
module apx_div_cell
    import apx_div_pkg::*;
#(
    parameter cell_kind_e KIND      = CELL_EXACT,
    parameter int         CELL_TYPE = 1
) (
    input  logic a,
    input  logic b,
    input  logic ctrl,
    input  logic bin,
    output logic d,
    output logic bo
);

    if (KIND == CELL_GONE) begin : g_gone
        logic unused_in;
        assign unused_in = ^{b, ctrl, bin};
        assign d  = a;
        assign bo = 1'b0;
    end else begin : g_live
        logic bx;
        logic bo_full;
        assign bx      = b ^ ctrl;
        assign bo_full = (~a & bx) | (~(a ^ bx) & bin);

        if (KIND == CELL_EXACT) begin : g_exact
            assign d  = a ^ bx ^ bin;
            assign bo = bo_full;
        end else if (CELL_TYPE == 1) begin : g_t1
            // borrow kept, difference collapsed to an OR
            assign d  = (a ^ bx) | bin;
            assign bo = bo_full;
        end else if (CELL_TYPE == 2) begin : g_t2
            // difference kept, borrow no longer ripples through
            logic unused_chain;
            assign unused_chain = bo_full;
            assign d  = a ^ bx ^ bin;
            assign bo = ~a & bx;
        end else begin : g_t3
            // borrow kept, difference picked by the incoming borrow
            assign d  = bin ? ~a : (a ^ bx);
            assign bo = bo_full;
        end
    end

endmodule

// File: rtl/apx_div_row.sv
module apx_div_row
    import apx_div_pkg::*;
#(
    parameter int N         = 4,
    parameter int ROW       = 0,
    parameter int MODE      = 0,
    parameter int SHAPE     = 0,
    parameter int DEPTH     = 0,
    parameter int CELL_TYPE = 1
) (
    input  logic [N:0]   a,
    input  logic [N-1:0] y,
    input  logic         ctrl,
    output logic [N:0]   d
);

    localparam int LVL = N - 1 - ROW;

    logic [N+1:0] bw;
    assign bw[0] = ctrl;

    for (genvar j = 0; j <= N; j++) begin : g_col
        localparam cell_kind_e K = cell_kind(MODE, SHAPE, DEPTH, LVL, j);
        logic bbit;
        if (j < N) begin : g_ybit
            assign bbit = y[j];
        end else begin : g_pad
            assign bbit = 1'b0;
        end
        apx_div_cell #(
            .KIND      (K),
            .CELL_TYPE (CELL_TYPE)
        ) u_cell (
            .a    (a[j]),
            .b    (bbit),
            .ctrl (ctrl),
            .bin  (bw[j]),
            .d    (d[j]),
            .bo   (bw[j+1])
        );
    end

    logic unused_top;
    assign unused_top = bw[N+1];

endmodule

// File: rtl/apx_div_fix.sv
module apx_div_fix #(
    parameter int N = 4
) (
    input  logic [N:0]   part,
    input  logic [N-1:0] y,
    output logic [N-1:0] r
);

    always_comb begin
        if (part[N]) r = part[N-1:0] + y;
        else         r = part[N-1:0];
    end

endmodule

// File: rtl/apx_div_array.sv
module apx_div_array
    import apx_div_pkg::*;
#(
    parameter int N         = 4,
    parameter int MODE      = MODE_EXACT,
    parameter int SHAPE     = SHAPE_VERT,
    parameter int DEPTH     = 0,
    parameter int CELL_TYPE = 1
) (
    input  logic [2*N-1:0] dividend,
    input  logic [N-1:0]   divisor,
    output logic [N-1:0]   quot,
    output logic [N-1:0]   rem
);

    localparam bit BAD_CFG = (N < 2) || (MODE < 0) || (MODE > 2) ||
                             (SHAPE < 0) || (SHAPE > 3) ||
                             (CELL_TYPE < 1) || (CELL_TYPE > 3) ||
                             (DEPTH < 0) || (DEPTH > N - 1);

    if (BAD_CFG) begin : g_bad_cfg
        $error("apx_div_array: illegal MODE/SHAPE/DEPTH/CELL_TYPE combination");
    end

    logic [N:0] part [1:N];

    for (genvar k = 0; k < N; k++) begin : g_row
        logic [N:0] a_in;
        logic       ctrl;
        if (k == 0) begin : g_first
            assign a_in = {dividend[2*N-1:N], dividend[N-1]};
            assign ctrl = 1'b0;
        end else begin : g_next
            assign a_in = {part[k][N-1:0], dividend[N-1-k]};
            assign ctrl = part[k][N];
        end
        apx_div_row #(
            .N         (N),
            .ROW       (k),
            .MODE      (MODE),
            .SHAPE     (SHAPE),
            .DEPTH     (DEPTH),
            .CELL_TYPE (CELL_TYPE)
        ) u_row (
            .a    (a_in),
            .y    (divisor),
            .ctrl (ctrl),
            .d    (part[k+1])
        );
        assign quot[N-1-k] = ~part[k+1][N];
    end

    apx_div_fix #(.N(N)) u_fix (
        .part (part[N]),
        .y    (divisor),
        .r    (rem)
    );

endmodule

// File: rtl/apx_div_chk.sv
module apx_div_chk #(
    parameter int N     = 4,
    parameter int MODE  = 0,
    parameter int SHAPE = 0,
    parameter int DEPTH = 0
) (
    input logic [2*N-1:0] x,
    input logic [N-1:0]   y,
    input logic [N-1:0]   q,
    input logic [N-1:0]   r
);

    localparam bit EXACT_OK = (MODE == 0) || (DEPTH == 0);
    localparam bit UPPER_OK = (MODE != 0) && (SHAPE == 1 || SHAPE == 3);

    logic [2*N-1:0] y_wide;
    logic [2*N-1:0] qref;
    logic [2*N-1:0] rref;
    logic           in_range;

    always_comb begin
        y_wide   = {{N{1'b0}}, y};
        qref     = (y != '0) ? x / y_wide : '0;
        rref     = (y != '0) ? x % y_wide : '0;
        in_range = (y != '0) && (x[2*N-1:N] < y);

        if (EXACT_OK && in_range) begin
            // R1
            quot_match_chk: assert (q == qref[N-1:0])
                else $error("quotient differs from integer division");
            // R1
            rem_bound_chk: assert ((r == rref[N-1:0]) && (r < y))
                else $error("remainder wrong or not below divisor");
        end
        if (EXACT_OK && (y != '0) && (x < y_wide)) begin
            // R2
            small_div_chk: assert ((q == '0) && (r == x[N-1:0]))
                else $error("dividend below divisor mishandled");
        end
        if (EXACT_OK && (y == N'(1)) && (x[2*N-1:N] == '0)) begin
            // R3
            unit_div_chk: assert ((q == x[N-1:0]) && (r == '0))
                else $error("unit divisor mishandled");
        end
        if (UPPER_OK && in_range) begin
            // R7
            upper_q_chk: assert ((q >> DEPTH) == (qref[N-1:0] >> DEPTH))
                else $error("quotient bits above the region disturbed");
        end
    end

endmodule

bind apx_div_array apx_div_chk #(
    .N     (N),
    .MODE  (MODE),
    .SHAPE (SHAPE),
    .DEPTH (DEPTH)
) u_chk (
    .x (dividend),
    .y (divisor),
    .q (quot),
    .r (rem)
);

// File: tb/apx_div_array_tb.sv
`timescale 1ns/1ps
module apx_div_array_tb;

    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2*N-1:0] x = '0;
    logic [N-1:0]   y = '0;
    int             total = 0;
    int             bad = 0;
    bit             done = 1'b0;

    logic [N-1:0] q_ex, r_ex, q_rz, r_rz, q_tz, r_tz, q_tv, r_tv, q_hr, r_hr, q_tr, r_tr;

    always #2 clk = ~clk;

    apx_div_array #(.N(N)) u_dut (
        .dividend(x), .divisor(y), .quot(q_ex), .rem(r_ex));
    apx_div_array #(.N(N), .MODE(1), .SHAPE(3), .DEPTH(0), .CELL_TYPE(2)) u_rz (
        .dividend(x), .divisor(y), .quot(q_rz), .rem(r_rz));
    apx_div_array #(.N(N), .MODE(2), .SHAPE(2), .DEPTH(0), .CELL_TYPE(1)) u_tz (
        .dividend(x), .divisor(y), .quot(q_tz), .rem(r_tz));
    apx_div_array #(.N(N), .MODE(2), .SHAPE(0), .DEPTH(2), .CELL_TYPE(1)) u_tv (
        .dividend(x), .divisor(y), .quot(q_tv), .rem(r_tv));
    apx_div_array #(.N(N), .MODE(1), .SHAPE(1), .DEPTH(2), .CELL_TYPE(2)) u_hr (
        .dividend(x), .divisor(y), .quot(q_hr), .rem(r_hr));
    apx_div_array #(.N(N), .MODE(1), .SHAPE(3), .DEPTH(3), .CELL_TYPE(3)) u_tr (
        .dividend(x), .divisor(y), .quot(q_tr), .rem(r_tr));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s x=%0d y=%0d actual=%0d expected=%0d", req, x, y, act, exp);
        end
    endtask

    task automatic apply(input int xv, input int yv);
        @(posedge clk);
        x = xv[2*N-1:0];
        y = yv[N-1:0];
        @(negedge clk);
    endtask

    // pass-through model of vertical truncation, depth >= 1
    function automatic int tv_model(input int xv, input int yv, input int d);
        int mfull, mlow, mhi, p, ctrl, q, a, b, hi, dd, r;
        mfull = (1 << (N + 1)) - 1;
        mlow  = (1 << d) - 1;
        mhi   = (1 << (N + 1 - d)) - 1;
        p = xv >> N;
        ctrl = 0;
        q = 0;
        dd = 0;
        for (int k = 0; k < N; k++) begin
            a  = ((p << 1) | ((xv >> (N - 1 - k)) & 1)) & mfull;
            b  = ctrl ? ((~yv & ((1 << N) - 1)) | (1 << N)) : yv;
            hi = ((a >> d) - (b >> d)) & mhi;
            dd = (hi << d) | (a & mlow);
            ctrl = (dd >> N) & 1;
            if (ctrl == 0) q = q | (1 << (N - 1 - k));
            p = dd & ((1 << N) - 1);
        end
        r = ctrl ? ((dd + yv) & ((1 << N) - 1)) : (dd & ((1 << N) - 1));
        return (q << N) | r;
    endfunction

    task automatic t_reset_state();
        apply(0, 1);
        // R2: zero dividend right after reset
        check(q_ex == 0 && r_ex == 0, "R2 reset state", {q_ex, r_ex}, 0);
    endtask

    task automatic t_exact_sweep();
        for (int yv = 1; yv < (1 << N); yv++)
            for (int xv = 0; xv < (yv << N); xv++) begin
                apply(xv, yv);
                check(q_ex == N'(xv / yv), "R1 quotient", q_ex, xv / yv);
                check(r_ex == N'(xv % yv), "R1 remainder", r_ex, xv % yv);
                check(q_rz == N'(xv / yv) && r_rz == N'(xv % yv), "R5 replace depth0",
                      {q_rz, r_rz}, ((xv / yv) << N) | (xv % yv));
                check(q_tz == N'(xv / yv) && r_tz == N'(xv % yv), "R5 truncate depth0",
                      {q_tz, r_tz}, ((xv / yv) << N) | (xv % yv));
            end
    endtask

    task automatic t_small();
        for (int yv = 1; yv < (1 << N); yv++)
            for (int xv = 0; xv < yv; xv++) begin
                apply(xv, yv);
                check(q_ex == 0 && r_ex == N'(xv), "R2 small dividend", {q_ex, r_ex}, xv);
            end
    endtask

    task automatic t_unit();
        for (int xv = 0; xv < (1 << N); xv++) begin
            apply(xv, 1);
            check(q_ex == N'(xv) && r_ex == 0, "R3 unit divisor", {q_ex, r_ex}, xv << N);
        end
    endtask

    task automatic t_top_edge();
        for (int yv = 1; yv < (1 << N); yv++) begin
            apply((yv << N) - 1, yv);
            check(q_ex == N'((1 << N) - 1) && r_ex == N'(yv - 1), "R4 top of range",
                  {q_ex, r_ex}, (((1 << N) - 1) << N) | (yv - 1));
        end
    endtask

    task automatic t_trunc_vert();
        int exp;
        for (int yv = 1; yv < (1 << N); yv++)
            for (int xv = 0; xv < (yv << N); xv++) begin
                apply(xv, yv);
                exp = tv_model(xv, yv, 2);
                check({q_tv, r_tv} == 8'(exp), "R6 vertical truncation", {q_tv, r_tv}, exp);
            end
    endtask

    task automatic t_upper_q();
        for (int yv = 1; yv < (1 << N); yv++)
            for (int xv = 0; xv < (yv << N); xv++) begin
                apply(xv, yv);
                check((q_hr >> 2) == N'((xv / yv) >> 2), "R7 horizontal upper q",
                      q_hr >> 2, (xv / yv) >> 2);
                check((q_tr >> 3) == N'((xv / yv) >> 3), "R7 triangle upper q",
                      q_tr >> 3, (xv / yv) >> 3);
            end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_small();
        t_unit();
        t_top_edge();
        t_exact_sweep();
        t_trunc_vert();
        t_upper_q();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule